// File: doc/BRIEF.md
# Serial Modulo-3 Remainder Tracker

This block reads a binary number one bit per clock, starting with the most significant bit, and keeps the remainder of the bits received so far after division by three. Each accepted bit updates that remainder. The number may be any length, and no frame marks where it starts or ends. A synchronous reset starts a new number.

The design is a three-state Moore machine. A small combinational step function computes the next remainder from the current remainder and the incoming bit. A register updated on the rising clock edge holds the remainder. A decode stage drives the remainder output and a divisible-by-three flag from the held state only. An input-valid strobe selects the cycles in which a bit is taken. In every other cycle the state is kept as it is.

Top module: `serial_rem3_tracker`

## Requirements
- R1: While `rst` is high at a rising edge, the state is cleared, so that `rem_out` is 2'b00 and `div_flag` is 1 after that edge.
- R2: On an edge where `bit_valid` is 1 and `bit_in` is 0, the remainder moves 0 to 0, 1 to 2 and 2 to 1.
- R3: On an edge where `bit_valid` is 1 and `bit_in` is 1, the remainder moves 0 to 1, 1 to 0 and 2 to 2.
- R4: On an edge where `bit_valid` is 0, the remainder does not change, whatever the value of `bit_in`.
- R5: After k accepted bits, `rem_out` equals the value of those k bits, read MSB first, modulo 3. It is encoded as the plain binary number 0, 1 or 2. The new value appears after the edge that takes the k-th bit.
- R6: `div_flag` is 1 exactly when `rem_out` is 2'b00.
- R7: `rem_out` never shows the unused code 2'b11. If the state register ever holds that code, the next accepted bit returns it to remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | High in cycles whose `bit_in` is taken |
| bit_in | input | 1 | Next bit of the number, MSB first |
| rem_out | output | 2 | Remainder modulo 3 of the bits taken so far |
| div_flag | output | 1 | High when the remainder is zero |

## Verification
The assertions assume that `bit_valid` and `bit_in` are stable, known values at each rising edge, and that reset is asserted at least once before any bit is sent. The stimulus changes inputs only on falling edges and always begins with a reset cycle. It sweeps every number of 1 to 10 bits. Idle cycles are placed between bits, and `bit_in` is toggled during them, so the hold rule is tested with both input values. The bench computes the expected remainder from the integer value of the prefix, not from the transition table.

// File: rtl/rem3_pkg.sv
package rem3_pkg;
  localparam int REM_W = 2;
  localparam logic [REM_W-1:0] REM_ZERO = 2'b00;
  localparam logic [REM_W-1:0] REM_ONE  = 2'b01;
  localparam logic [REM_W-1:0] REM_TWO  = 2'b10;

  // Appending bit b to a prefix with remainder r gives (2r + b) mod 3.
  function automatic logic [REM_W-1:0] rem3_step(input logic [REM_W-1:0] r, input logic b);
    logic [REM_W-1:0] res;
    case (r)
      REM_ZERO: res = b ? REM_ONE  : REM_ZERO;
      REM_ONE:  res = b ? REM_ZERO : REM_TWO;
      REM_TWO:  res = b ? REM_TWO  : REM_ONE;
      default:  res = REM_ZERO; // unused code: recover to zero (R7)
    endcase
    return res;
  endfunction
endpackage

// File: rtl/rem3_next_logic.sv
module rem3_next_logic
  import rem3_pkg::*;
(
  input  logic [REM_W-1:0] cur_state,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic [REM_W-1:0] nxt_state,
  output logic             step_taken,
  output logic             illegal_state
);
  always_comb begin
    step_taken    = bit_valid;
    illegal_state = (cur_state == 2'b11);
    nxt_state     = bit_valid ? rem3_step(cur_state, bit_in) : cur_state;
  end
endmodule

// File: rtl/rem3_state_bank.sv
module rem3_state_bank
  import rem3_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REM_W-1:0] nxt_state,
  output logic [REM_W-1:0] cur_state
);
  always_ff @(posedge clk) begin
    if (rst) cur_state <= REM_ZERO;
    else     cur_state <= nxt_state;
  end
endmodule

// File: rtl/rem3_out_decode.sv
module rem3_out_decode
  import rem3_pkg::*;
(
  input  logic [REM_W-1:0] cur_state,
  output logic [REM_W-1:0] rem_out,
  output logic             div_flag
);
  always_comb begin
    rem_out  = (cur_state == 2'b11) ? REM_ZERO : cur_state;
    div_flag = (cur_state == REM_ZERO) || (cur_state == 2'b11);
  end
endmodule

// File: rtl/serial_rem3_tracker.sv
module serial_rem3_tracker
  import rem3_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_valid,
  input  logic       bit_in,
  output logic [1:0] rem_out,
  output logic       div_flag
);
  logic [REM_W-1:0] cur_state;
  logic [REM_W-1:0] nxt_state;
  logic             step_taken;
  logic             illegal_state;

  rem3_next_logic u_next (
    .cur_state    (cur_state),
    .bit_valid    (bit_valid),
    .bit_in       (bit_in),
    .nxt_state    (nxt_state),
    .step_taken   (step_taken),
    .illegal_state(illegal_state)
  );

  rem3_state_bank u_bank (
    .clk      (clk),
    .rst      (rst),
    .nxt_state(nxt_state),
    .cur_state(cur_state)
  );

  rem3_out_decode u_dec (
    .cur_state(cur_state),
    .rem_out  (rem_out),
    .div_flag (div_flag)
  );
endmodule

// File: rtl/rem3_checker.sv
module rem3_checker (
  input logic       clk,
  input logic       rst,
  input logic       bit_valid,
  input logic       bit_in,
  input logic [1:0] rem_out,
  input logic       div_flag,
  input logic       step_taken,
  input logic       illegal_state
);
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> (rem_out == 2'b00));

  p_zero_from0_r2: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_in && rem_out == 2'd0) |=> (rem_out == 2'd0));
  p_zero_from1_r2: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_in && rem_out == 2'd1) |=> (rem_out == 2'd2));
  p_zero_from2_r2: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_in && rem_out == 2'd2) |=> (rem_out == 2'd1));

  p_one_from0_r3: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && bit_in && rem_out == 2'd0) |=> (rem_out == 2'd1));
  p_one_from1_r3: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && bit_in && rem_out == 2'd1) |=> (rem_out == 2'd0));
  p_one_from2_r3: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && bit_in && rem_out == 2'd2) |=> (rem_out == 2'd2));

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !step_taken |=> $stable(rem_out));

  p_flag_match_r6: assert property (@(posedge clk) disable iff (rst)
    div_flag == (rem_out == 2'b00));

  p_no_bad_code_r7: assert property (@(posedge clk) disable iff (rst)
    (rem_out != 2'b11) && !illegal_state);
endmodule

bind serial_rem3_tracker rem3_checker u_rem3_checker (
  .clk          (clk),
  .rst          (rst),
  .bit_valid    (bit_valid),
  .bit_in       (bit_in),
  .rem_out      (rem_out),
  .div_flag     (div_flag),
  .step_taken   (step_taken),
  .illegal_state(illegal_state)
);

// File: tb/test_serial_rem3_tracker.sv
`timescale 1ns/1ps
module test_serial_rem3_tracker;
  localparam int MAX_BITS = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic [1:0] rem_out;
  logic       div_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk; // 200 MHz

  serial_rem3_tracker i_serial_rem3_tracker (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .rem_out(rem_out), .div_flag(div_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs change on falling edges; results are read on the next falling edge.
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 rem after reset", rem_out, 0);
    check("R1 flag after reset", div_flag, 1);
  endtask

  task automatic run_number(input int width, input int value);
    int prefix = 0;
    for (int i = width - 1; i >= 0; i--) begin
      logic b;
      int prev;
      b = value[i];
      prev = prefix % 3;
      bit_valid = 1'b1; bit_in = b;
      @(negedge clk);
      prefix = prefix * 2 + int'(b);
      if (b) check("R3 step on bit 1", rem_out, (2 * prev + 1) % 3);
      else   check("R2 step on bit 0", rem_out, (2 * prev) % 3);
      check("R5 prefix mod 3", rem_out, prefix % 3);
      check("R6 divisible flag", div_flag, (prefix % 3 == 0) ? 1 : 0);
      check("R7 no unused code", (rem_out == 2'b11) ? 1 : 0, 0);
      if (((value + i) % 3) == 0) begin
        bit_valid = 1'b0; bit_in = ~b;
        @(negedge clk);
        check("R4 hold while idle", rem_out, prefix % 3);
        check("R6 flag while idle", div_flag, (prefix % 3 == 0) ? 1 : 0);
      end
    end
    bit_valid = 1'b0;
  endtask

  initial begin
    do_reset();
    for (int w = 1; w <= MAX_BITS; w++) begin
      for (int v = 0; v < (1 << w); v++) begin
        do_reset();
        run_number(w, v);
      end
    end
    // Reset in the middle of a number: R1.
    run_number(4, 5);
    @(negedge clk);
    rst = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    rst = 1'b0; bit_valid = 1'b0;
    check("R1 reset overrides valid bit", rem_out, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule